// File: doc/BRIEF.md
# PC Card Flash Array Control Decoder

This block is the card-side control logic between a 16-bit PC Card host bus and an array of flash devices grouped in pairs. Each pair has one device on the even (low) byte lane and one on the odd (high) byte lane. The block decodes the host's active-low card enables, output enable, write enable and attribute-plane select, together with address bit 0 and the upper address bits. From these it produces one chip select per pair, shared read and write strobes for each device lane, write-data steering to the devices, and read-data steering with lane drive enables toward the host.

An 8-bit host reaches every byte on the low host lane. It asserts only the even-lane enable and uses address bit 0 to choose between the even device and the odd device of a pair. A 16-bit host asserts both enables and moves a whole word. With the attribute-plane select low, accesses go to a small internal byte store that holds the card's identification data, and no flash device is touched. The ready lines of all devices are combined into a single registered card-ready output. A write-protect input locks out every flash write strobe. An active-high reset forces the card idle, and the wait output is held inactive at all times.

Top module: `pcc_flash_ctl`

## Requirements
- R1: With both enables low (`ce1_n`=0, `ce2_n`=0), `host_addr[0]` is ignored. The low-lane device's byte appears on `host_rdata[7:0]` and the high-lane device's byte on `host_rdata[15:8]`, and both lane strobes of the selected pair are active.
- R2: With only `ce1_n` low and `host_addr[0]`=0, only the low-lane device strobe is active, and its byte is driven on `host_rdata[7:0]` alone.
- R3: With only `ce1_n` low and `host_addr[0]`=1, only the high-lane device strobe is active. Its byte is returned on `host_rdata[7:0]`, and on a write `dev_wdata_hi` carries `host_wdata[7:0]`. In every other mode `dev_wdata_hi` carries `host_wdata[15:8]`, and `dev_wdata_lo` always carries `host_wdata[7:0]`.
- R4: With only `ce2_n` low, only the high-lane device strobe is active and only `host_rdata[15:8]` is driven. With both enables high, nothing is selected or driven. An undriven host lane reads as zero.
- R5: The pair index is `host_addr[ADDR_W-1:PAIR_LSB]`. During a flash access, exactly the chip select `pair_cs_n[index]` goes low. At most one chip select is low at any time.
- R6: An index at or above `NUM_PAIRS` selects no pair and drives no device strobe. Every driven host lane reads 8'hFF.
- R7: While `wp` is high, `wr_lo_n` and `wr_hi_n` stay high. Chip selects and reads are unaffected.
- R8: Host lanes are driven only while `oe_n`=0, `we_n`=1 and an enable is low. Write strobes occur only while `we_n`=0, and a low `we_n` suppresses the read path.
- R9: With `reg_n`=0, no chip select or device strobe is active. The even lane (word mode or `host_addr[0]`=0) reads the attribute byte at index `host_addr[ATTR_AW:1]`, and an odd-lane read returns 8'hFF. A write through the even lane stores `host_wdata[7:0]` at that index on the next clock edge. `wp` does not block it.
- R10: `card_ready` is high one clock after all `dev_ready` bits are high, and low one clock after any of them is low.
- R11: While `rst` is high, all chip selects and strobes are high, no host lane is driven, no attribute write occurs and `card_ready` is low. `wait_n` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high card reset |
| host_addr | input | ADDR_W | Host byte address |
| ce1_n | input | 1 | Even-lane card enable, active low |
| ce2_n | input | 1 | Odd-lane card enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| reg_n | input | 1 | Attribute-plane select, active low |
| wp | input | 1 | Write-protect, high locks flash writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the host |
| host_oe_lo | output | 1 | Drive enable for host lane 7:0 |
| host_oe_hi | output | 1 | Drive enable for host lane 15:8 |
| wait_n | output | 1 | Wait request, always inactive high |
| card_ready | output | 1 | Registered AND of all device ready lines |
| pair_cs_n | output | NUM_PAIRS | Per-pair chip select, active low |
| rd_lo_n | output | 1 | Low-lane device read strobe |
| rd_hi_n | output | 1 | High-lane device read strobe |
| wr_lo_n | output | 1 | Low-lane device write strobe |
| wr_hi_n | output | 1 | High-lane device write strobe |
| dev_wdata_lo | output | 8 | Write data to low-lane devices |
| dev_wdata_hi | output | 8 | Write data to high-lane devices |
| dev_rdata_lo | input | NUM_PAIRS*8 | Read data from each pair's low device |
| dev_rdata_hi | input | NUM_PAIRS*8 | Read data from each pair's high device |
| dev_ready | input | 2*NUM_PAIRS | Ready line of every device |

## Verification
Write protection and the lane steering of a write act on the same strobe in the same cycle. The sweep crosses `wp` with every enable, address-bit-0 and `oe_n`/`we_n` combination over every address, so a protected odd-byte write must still steer its data while showing no write strobe. Attribute selection and out-of-range pair decode also coincide across the sweep, and attribute access must take precedence. The bench judges each vector against its own decode and its own mirror of the attribute store.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    LM_IDLE     = 3'd0,
    LM_WORD     = 3'd1,
    LM_EVEN     = 3'd2,
    LM_ODD_LOW  = 3'd3,
    LM_ODD_HIGH = 3'd4
  } lane_mode_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic lane_mode_e lane_mode_of(input logic ce_lo, input logic ce_hi,
                                               input logic a0);
    lane_mode_e m;
    if (ce_lo && ce_hi)       m = LM_WORD;
    else if (ce_lo && !a0)    m = LM_EVEN;
    else if (ce_lo)           m = LM_ODD_LOW;
    else if (ce_hi)           m = LM_ODD_HIGH;
    else                      m = LM_IDLE;
    return m;
  endfunction

  function automatic logic uses_lo_dev(input lane_mode_e m);
    return (m == LM_WORD) || (m == LM_EVEN);
  endfunction

  function automatic logic uses_hi_dev(input lane_mode_e m);
    return (m == LM_WORD) || (m == LM_ODD_LOW) || (m == LM_ODD_HIGH);
  endfunction

  function automatic logic drives_host_lo(input lane_mode_e m);
    return (m == LM_WORD) || (m == LM_EVEN) || (m == LM_ODD_LOW);
  endfunction

  function automatic logic drives_host_hi(input lane_mode_e m);
    return (m == LM_WORD) || (m == LM_ODD_HIGH);
  endfunction

endpackage

// File: rtl/pcc_lane_decode.sv
module pcc_lane_decode
  import pcc_pkg::*;
(
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       a0,
  output lane_mode_e mode,
  output logic       ce_any,
  output logic       lo_dev,
  output logic       hi_dev,
  output logic       host_lo,
  output logic       host_hi
);

  always_comb begin
    mode    = lane_mode_of(!ce1_n, !ce2_n, a0);
    ce_any  = !ce1_n || !ce2_n;
    lo_dev  = uses_lo_dev(mode);
    hi_dev  = uses_hi_dev(mode);
    host_lo = drives_host_lo(mode);
    host_hi = drives_host_hi(mode);
  end

endmodule

// File: rtl/pcc_pair_select.sv
module pcc_pair_select #(
  parameter int ADDR_W    = 26,
  parameter int PAIR_LSB  = 22,
  parameter int NUM_PAIRS = 10,
  localparam int PIDX_W   = ADDR_W - PAIR_LSB
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 enable,
  output logic [PIDX_W-1:0]    pair_idx,
  output logic                 pair_hit,
  output logic [NUM_PAIRS-1:0] cs_n
);

  assign pair_idx = addr[ADDR_W-1:PAIR_LSB];
  assign pair_hit = ({1'b0, pair_idx} < (PIDX_W+1)'(NUM_PAIRS));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cs
    assign cs_n[p] = !(enable && (pair_idx == PIDX_W'(p)));
  end

endmodule

// File: rtl/pcc_attr_store.sv
module pcc_attr_store #(
  parameter int ATTR_AW = 11,
  localparam int DEPTH  = 1 << ATTR_AW
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ATTR_AW-1:0] idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/pcc_ready_merge.sv
module pcc_ready_merge #(
  parameter int N_DEV = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] dev_ready,
  output logic             ready
);

  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b0;
    else     ready <= &dev_ready;
  end

endmodule

// File: rtl/pcc_flash_ctl.sv
module pcc_flash_ctl
  import pcc_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int PAIR_LSB  = 22,
  parameter int NUM_PAIRS = 10,
  parameter int ATTR_AW   = 11,
  localparam int PIDX_W   = ADDR_W - PAIR_LSB,
  localparam int N_DEV    = 2 * NUM_PAIRS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic                   ce1_n,
  input  logic                   ce2_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic                   reg_n,
  input  logic                   wp,
  input  logic [15:0]            host_wdata,
  output logic [15:0]            host_rdata,
  output logic                   host_oe_lo,
  output logic                   host_oe_hi,
  output logic                   wait_n,
  output logic                   card_ready,
  output logic [NUM_PAIRS-1:0]   pair_cs_n,
  output logic                   rd_lo_n,
  output logic                   rd_hi_n,
  output logic                   wr_lo_n,
  output logic                   wr_hi_n,
  output logic [7:0]             dev_wdata_lo,
  output logic [7:0]             dev_wdata_hi,
  input  logic [NUM_PAIRS*8-1:0] dev_rdata_lo,
  input  logic [NUM_PAIRS*8-1:0] dev_rdata_hi,
  input  logic [N_DEV-1:0]       dev_ready
);

  // named internal events
  lane_mode_e        mode;
  logic              ce_any, lo_dev, hi_dev, host_lo, host_hi;
  logic              rd_ok, wr_ok, is_attr, flash_go, pair_hit, attr_wr;
  logic [PIDX_W-1:0] pair_idx;
  logic [7:0]        attr_q, sel_lo, sel_hi, lo_byte, hi_byte;

  pcc_lane_decode u_lane (
    .ce1_n  (ce1_n),
    .ce2_n  (ce2_n),
    .a0     (host_addr[0]),
    .mode   (mode),
    .ce_any (ce_any),
    .lo_dev (lo_dev),
    .hi_dev (hi_dev),
    .host_lo(host_lo),
    .host_hi(host_hi)
  );

  assign is_attr  = !reg_n;
  assign rd_ok    = !rst && ce_any && !oe_n && we_n;
  assign wr_ok    = !rst && ce_any && !we_n;
  assign flash_go = (rd_ok || wr_ok) && !is_attr;
  assign attr_wr  = wr_ok && is_attr && lo_dev;

  pcc_pair_select #(
    .ADDR_W   (ADDR_W),
    .PAIR_LSB (PAIR_LSB),
    .NUM_PAIRS(NUM_PAIRS)
  ) u_pair (
    .addr    (host_addr),
    .enable  (flash_go),
    .pair_idx(pair_idx),
    .pair_hit(pair_hit),
    .cs_n    (pair_cs_n)
  );

  pcc_attr_store #(.ATTR_AW(ATTR_AW)) u_attr (
    .clk  (clk),
    .wr_en(attr_wr),
    .idx  (host_addr[ATTR_AW:1]),
    .wdata(host_wdata[7:0]),
    .rdata(attr_q)
  );

  pcc_ready_merge #(.N_DEV(N_DEV)) u_rdy (
    .clk      (clk),
    .rst      (rst),
    .dev_ready(dev_ready),
    .ready    (card_ready)
  );

  // device strobes
  assign rd_lo_n = !(rd_ok && !is_attr && pair_hit && lo_dev);
  assign rd_hi_n = !(rd_ok && !is_attr && pair_hit && hi_dev);
  assign wr_lo_n = !(wr_ok && !is_attr && pair_hit && lo_dev && !wp);
  assign wr_hi_n = !(wr_ok && !is_attr && pair_hit && hi_dev && !wp);

  // write steering: odd byte from an 8-bit host rides the low host lane
  assign dev_wdata_lo = host_wdata[7:0];
  assign dev_wdata_hi = (mode == LM_ODD_LOW) ? host_wdata[7:0] : host_wdata[15:8];

  // read path
  always_comb begin
    sel_lo = FILL_BYTE;
    sel_hi = FILL_BYTE;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pair_idx == PIDX_W'(p)) begin
        sel_lo = dev_rdata_lo[p*8 +: 8];
        sel_hi = dev_rdata_hi[p*8 +: 8];
      end
    end
  end

  always_comb begin
    if (is_attr)                 lo_byte = (mode == LM_ODD_LOW) ? FILL_BYTE : attr_q;
    else if (!pair_hit)          lo_byte = FILL_BYTE;
    else if (mode == LM_ODD_LOW) lo_byte = sel_hi;
    else                         lo_byte = sel_lo;
    hi_byte = (is_attr || !pair_hit) ? FILL_BYTE : sel_hi;
  end

  assign host_oe_lo = rd_ok && host_lo;
  assign host_oe_hi = rd_ok && host_hi;
  assign host_rdata = {host_oe_hi ? hi_byte : 8'h00, host_oe_lo ? lo_byte : 8'h00};
  assign wait_n     = 1'b1;

endmodule

// File: rtl/pcc_flash_ctl_chk.sv
module pcc_flash_ctl_chk #(
  parameter int NUM_PAIRS = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ce1_n,
  input logic                   ce2_n,
  input logic                   we_n,
  input logic                   reg_n,
  input logic                   wp,
  input logic                   host_oe_lo,
  input logic                   host_oe_hi,
  input logic                   card_ready,
  input logic [NUM_PAIRS-1:0]   pair_cs_n,
  input logic                   rd_lo_n,
  input logic                   rd_hi_n,
  input logic                   wr_lo_n,
  input logic                   wr_hi_n,
  input logic [2*NUM_PAIRS-1:0] dev_ready,
  input logic                   attr_wr
);

  AST_ONE_PAIR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pair_cs_n)); // R5

  AST_NO_CE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && ce2_n) |-> (&pair_cs_n && !host_oe_lo && !host_oe_hi)); // R4

  AST_WP_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    wp |-> (wr_lo_n && wr_hi_n)); // R7

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!host_oe_lo && !host_oe_hi && rd_lo_n && rd_hi_n)); // R8

  AST_ATTR_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    !reg_n |-> (&pair_cs_n && rd_lo_n && rd_hi_n && wr_lo_n && wr_hi_n)); // R9

  AST_READY_ALL: assert property (@(posedge clk) disable iff (rst)
    (&dev_ready) |=> card_ready); // R10

  AST_BUSY_ANY: assert property (@(posedge clk) disable iff (rst)
    !(&dev_ready) |=> !card_ready); // R10

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_IDLE: assert (&pair_cs_n && rd_lo_n && rd_hi_n && wr_lo_n && wr_hi_n
                              && !host_oe_lo && !host_oe_hi && !attr_wr); // R11
    end
  end

endmodule

bind pcc_flash_ctl pcc_flash_ctl_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce1_n     (ce1_n),
  .ce2_n     (ce2_n),
  .we_n      (we_n),
  .reg_n     (reg_n),
  .wp        (wp),
  .host_oe_lo(host_oe_lo),
  .host_oe_hi(host_oe_hi),
  .card_ready(card_ready),
  .pair_cs_n (pair_cs_n),
  .rd_lo_n   (rd_lo_n),
  .rd_hi_n   (rd_hi_n),
  .wr_lo_n   (wr_lo_n),
  .wr_hi_n   (wr_hi_n),
  .dev_ready (dev_ready),
  .attr_wr   (attr_wr)
);

// File: tb/pcc_flash_ctl_tb.sv
module pcc_flash_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int PL  = 5;
  localparam int NP  = 3;
  localparam int TAW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1, wp = 1'b0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic host_oe_lo, host_oe_hi, wait_n, card_ready;
  logic [NP-1:0] pair_cs_n;
  logic rd_lo_n, rd_hi_n, wr_lo_n, wr_hi_n;
  logic [7:0]    dev_wdata_lo, dev_wdata_hi;
  logic [NP*8-1:0] dev_rdata_lo, dev_rdata_hi;
  logic [2*NP-1:0] dev_ready = '1;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] amodel [1<<TAW];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_dev
    assign dev_rdata_lo[p*8 +: 8] = 8'hA0 | 8'(p);
    assign dev_rdata_hi[p*8 +: 8] = 8'h50 | 8'(p);
  end

  pcc_flash_ctl #(.ADDR_W(AW), .PAIR_LSB(PL), .NUM_PAIRS(NP), .ATTR_AW(TAW)) u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .oe_n(oe_n), .we_n(we_n), .reg_n(reg_n), .wp(wp), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
    .wait_n(wait_n), .card_ready(card_ready), .pair_cs_n(pair_cs_n),
    .rd_lo_n(rd_lo_n), .rd_hi_n(rd_hi_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .dev_wdata_lo(dev_wdata_lo), .dev_wdata_hi(dev_wdata_hi),
    .dev_rdata_lo(dev_rdata_lo), .dev_rdata_hi(dev_rdata_hi), .dev_ready(dev_ready)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // one vector per clock: drive after negedge, check 1 time unit later
  task automatic apply(input logic [AW-1:0] a, input logic c1, input logic c2,
                       input logic o, input logic w, input logic r, input logic p,
                       input logic [15:0] wd, input bit check);
    logic lo, hi, word, bev, bodd, ohi, anyce, rd, wr, attr, hit, ldev, hdev;
    logic [NP-1:0] ecs;
    logic [7:0] elo, ehi;
    int pi, ix;
    string tag;
    @(negedge clk);
    host_addr = a; ce1_n = c1; ce2_n = c2; oe_n = o; we_n = w; reg_n = r; wp = p;
    host_wdata = wd;
    #1;
    lo = !c1; hi = !c2;
    word = lo && hi; bev = lo && !hi && !a[0]; bodd = lo && !hi && a[0]; ohi = !lo && hi;
    anyce = lo || hi;
    rd = !o && w && anyce; wr = !w && anyce; attr = !r;
    pi = int'(a[AW-1:PL]); ix = int'(a[TAW:1]);
    hit = (pi < NP);
    ldev = word || bev; hdev = word || bodd || ohi;
    for (int k = 0; k < NP; k++) ecs[k] = !((rd || wr) && !attr && pi == k);
    if (bodd) elo = attr ? 8'hFF : (!hit ? 8'hFF : (8'h50 | 8'(pi)));
    else      elo = attr ? amodel[ix] : (!hit ? 8'hFF : (8'hA0 | 8'(pi)));
    ehi = (attr || !hit) ? 8'hFF : (8'h50 | 8'(pi));
    if (!(rd && (word || bev || bodd))) elo = 8'h00;
    if (!(rd && (word || ohi)))         ehi = 8'h00;
    if (attr)                 tag = "R9";
    else if (!hit)            tag = "R6";
    else if (p && wr)         tag = "R7";
    else if (!(o ^ w))        tag = "R8";
    else if (word)            tag = "R1";
    else if (bev)             tag = "R2";
    else if (bodd)            tag = "R3";
    else                      tag = "R4";
    if (check) begin
      chk(tag, "pair_cs_n R5", 32'(pair_cs_n), 32'(ecs));
      chk(tag, "read strobes", {30'd0, rd_lo_n, rd_hi_n},
          {30'd0, !(rd && !attr && hit && ldev), !(rd && !attr && hit && hdev)});
      chk(tag, "write strobes", {30'd0, wr_lo_n, wr_hi_n},
          {30'd0, !(wr && !attr && hit && ldev && !p), !(wr && !attr && hit && hdev && !p)});
      chk(tag, "lane enables", {30'd0, host_oe_lo, host_oe_hi},
          {30'd0, rd && (word || bev || bodd), rd && (word || ohi)});
      chk(tag, "host_rdata", 32'(host_rdata), {16'd0, ehi, elo});
      chk(tag, "dev_wdata R3", {16'd0, dev_wdata_hi, dev_wdata_lo},
          {16'd0, bodd ? wd[7:0] : wd[15:8], wd[7:0]});
    end
    // the attribute store takes the write at the coming posedge
    if (wr && attr && ldev) amodel[ix] = wd[7:0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset with every strobe requested
    host_addr = '0; ce1_n = 0; ce2_n = 0; oe_n = 0; we_n = 1; reg_n = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R11", "cs in reset", 32'(pair_cs_n), 32'({NP{1'b1}}));
    chk("R11", "strobes in reset", {28'd0, rd_lo_n, rd_hi_n, wr_lo_n, wr_hi_n}, 32'hF);
    chk("R11", "lanes in reset", {30'd0, host_oe_lo, host_oe_hi}, 32'd0);
    chk("R11", "ready in reset", 32'(card_ready), 32'd0);
    chk("R11", "wait_n", 32'(wait_n), 32'd1);
    we_n = 0; reg_n = 0; host_wdata = 16'h00C3;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 0; we_n = 1; ce1_n = 1; ce2_n = 1; reg_n = 1;

    // R10: ready merge, registered one cycle
    @(posedge clk); #1;
    chk("R10", "ready after reset", 32'(card_ready), 32'd1);
    for (int k = 0; k < 2*NP; k++) begin
      @(negedge clk);
      dev_ready = '1;
      dev_ready[k] = 1'b0;
      #1;
      chk("R10", "ready before edge", 32'(card_ready), 32'd1);
      @(posedge clk); #1;
      chk("R10", "busy device seen", 32'(card_ready), 32'd0);
      @(negedge clk);
      dev_ready = '1;
      @(posedge clk); #1;
      chk("R10", "all ready again", 32'(card_ready), 32'd1);
    end

    // preload the attribute store through the even lane (R9)
    for (int i = 0; i < (1 << TAW); i++)
      apply(AW'(i << 1), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'(16'h3C00 + i * 7), 1'b0);

    // exhaustive sweep: address x enables x oe/we x reg x wp
    for (int v = 0; v < (1 << 14); v++) begin
      logic [13:0] b;
      b = 14'(v);
      apply(b[7:0], b[8], b[9], b[10], b[11], b[12], b[13],
            16'(v * 16'h9E37 + 16'h1234), 1'b1);
    end

    @(negedge clk);
    ce1_n = 1; ce2_n = 1; we_n = 1; oe_n = 1;
    chk("R11", "wait_n held", 32'(wait_n), 32'd1);
    finish_run();
  end

endmodule